// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits behind the framing and de-stuffing logic of an HDLC receiver and looks at the address field at the head of every frame. It decides whether the frame is for this station. If the frame is accepted, it reports which compare pair matched, whether that pair is the one connection handled automatically, and the command/response indication. Frames that match no valid address are dropped quietly. All their later bytes are held back by gating the byte-valid strobe.

A frame is bounded by a start strobe and an end strobe, each of which carries no data. Bytes arrive with a valid strobe. Two formats are supported. In the one-byte format, the single address byte is checked against two low compare values. In the two-byte format, the high byte is checked against two programmable values and a fixed group value, and the low byte is checked against two programmable values. Per-bit don't-care masks allow broadcast recognition. An option removes the command/response bit from every high-byte comparison.

Top module: `hdlc_addr_filter`

## Requirements
- R1: In two-byte mode (cfg_two_byte=1) a frame is accepted exactly when the first address byte matches one of the high candidates and the second address byte matches one of the low candidates. The high candidates are cfg_hi1, cfg_hi2 and the group value 0xFE. The low candidates are cfg_lo1 and cfg_lo2.
- R2: With cfg_cr_ignore=1, bit 1 of the high byte is excluded from all three high comparisons, so 0xFC also matches the group value. In that case addr_cr reports bit 1 of the received high byte. With cfg_cr_ignore=0, addr_cr is 0 in two-byte mode.
- R3: addr_idx = 2*h + l, where h is 0 for cfg_hi1, 1 for cfg_hi2 and 2 for the group value, and l is 0 for cfg_lo1 and 1 for cfg_lo2. When several pairs match, the lowest index is reported. addr_idx is 0 on a reject.
- R4: addr_auto is 1 exactly when the frame is accepted with addr_idx = 0. That is the cfg_hi1/cfg_lo1 pair in two-byte mode, or cfg_lo1 in one-byte mode.
- R5: In one-byte mode (cfg_two_byte=0) the single address byte is compared with cfg_lo1 and cfg_lo2 only, and cfg_hi1 and cfg_hi2 have no effect. A cfg_lo1 match gives addr_idx=0 and addr_cr=1 (command). A cfg_lo2-only match gives addr_idx=1 and addr_cr=0 (response).
- R6: A 1 in cfg_hi_mask makes that bit position always match for cfg_hi1 and cfg_hi2, but not for the group value. A 1 in cfg_lo_mask does the same for cfg_lo1 and cfg_lo2.
- R7: addr_done rises in the cycle after the clock edge that samples the last address byte. The decision outputs then hold until the next rx_sof, which clears addr_done on the following cycle.
- R8: A frame whose rx_eof arrives before its address field is complete ends with addr_done=1 and addr_accept=0.
- R9: out_valid equals rx_valid only for bytes that follow the address field of an accepted frame, before its rx_eof. Address bytes, bytes of dropped frames and bytes outside a frame give out_valid=0. out_byte carries rx_byte.
- R10: After reset addr_done, addr_accept, addr_auto, addr_cr, addr_idx and out_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_sof | input | 1 | Frame start strobe (no data) |
| rx_valid | input | 1 | Byte valid strobe |
| rx_byte | input | W | Received byte |
| rx_eof | input | 1 | Frame end strobe (no data) |
| cfg_two_byte | input | 1 | 1: two-byte address, 0: one-byte address |
| cfg_cr_ignore | input | 1 | Exclude the command/response bit from high comparisons |
| cfg_hi1 | input | W | First high compare value |
| cfg_hi2 | input | W | Second high compare value |
| cfg_lo1 | input | W | First low compare value |
| cfg_lo2 | input | W | Second low compare value |
| cfg_hi_mask | input | W | Don't-care bits for the high compare values |
| cfg_lo_mask | input | W | Don't-care bits for the low compare values |
| addr_done | output | 1 | Address decision is valid |
| addr_accept | output | 1 | Frame accepted |
| addr_auto | output | 1 | Frame belongs to the automatically handled connection |
| addr_cr | output | 1 | Command/response indication |
| addr_idx | output | 3 | Index of the matching candidate pair |
| out_valid | output | 1 | Gated byte valid for post-address bytes |
| out_byte | output | W | Forwarded byte |

## Verification
The assertions check, on every cycle, the rules that tie outputs together. Forwarded bytes only appear after an accepting decision, and the auto flag only appears with pair index zero. A decision stays frozen until the next frame start, a frame start clears it, an early frame end produces a reject, and the index stays in range. Whether the right pair was chosen for a given byte and configuration can only be shown by the bench's sweeps. These cover every high byte against several low bytes, overlapping candidates for the priority order, masks, the command/response option and every byte in one-byte mode. The bench scenarios also cover short frames and stray bytes outside a frame.

// File: rtl/hdlc_addr_pkg.sv
package hdlc_addr_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_HI    = 3;
    localparam int NUM_LO    = 2;
    localparam int NUM_PAIRS = NUM_HI * NUM_LO;
    localparam int IDX_W     = $clog2(NUM_PAIRS);

    typedef struct packed {
        logic              in_frame;
        logic              got_hi;
        logic              done;
        logic              accept;
        logic              auto_f;
        logic              cr;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] hi_byte;
    } filt_state_t;
endpackage

// File: rtl/hdlc_addr_cmp.sv
module hdlc_addr_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] ref_val,
    input  logic [W-1:0] dc_mask,
    output logic         hit
);
    // A don't-care bit always matches.
    assign hit = (((value ^ ref_val) & ~dc_mask) == '0);
endmodule

// File: rtl/hdlc_addr_match.sv
module hdlc_addr_match
    import hdlc_addr_pkg::*;
#(
    parameter int          W          = BYTE_W,
    parameter logic [W-1:0] GROUP_ADDR = 8'hFE,
    parameter int          CR_BIT     = 1
) (
    input  logic             two_byte,
    input  logic             cr_ignore,
    input  logic [W-1:0]     hi_byte,
    input  logic [W-1:0]     lo_byte,
    input  logic [W-1:0]     hi1,
    input  logic [W-1:0]     hi2,
    input  logic [W-1:0]     lo1,
    input  logic [W-1:0]     lo2,
    input  logic [W-1:0]     hi_mask,
    input  logic [W-1:0]     lo_mask,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic             cr
);
    logic [W-1:0]         crm;
    logic [W-1:0]         hi_ref [NUM_HI];
    logic [W-1:0]         hi_dc  [NUM_HI];
    logic [W-1:0]         lo_ref [NUM_LO];
    logic [W-1:0]         lo_dc  [NUM_LO];
    logic [NUM_HI-1:0]    hi_hit;
    logic [NUM_LO-1:0]    lo_hit;
    logic [NUM_PAIRS-1:0] pair_hit;

    always_comb begin
        crm       = cr_ignore ? (W'(1) << CR_BIT) : '0;
        hi_ref[0] = hi1;
        hi_ref[1] = hi2;
        hi_ref[2] = GROUP_ADDR;
        hi_dc[0]  = hi_mask | crm;
        hi_dc[1]  = hi_mask | crm;
        hi_dc[2]  = crm;
        lo_ref[0] = lo1;
        lo_ref[1] = lo2;
        lo_dc[0]  = lo_mask;
        lo_dc[1]  = lo_mask;
    end

    for (genvar g = 0; g < NUM_HI; g++) begin : g_hi
        hdlc_addr_cmp #(.W(W)) u_cmp (
            .value  (hi_byte),
            .ref_val(hi_ref[g]),
            .dc_mask(hi_dc[g]),
            .hit    (hi_hit[g])
        );
    end

    for (genvar g = 0; g < NUM_LO; g++) begin : g_lo
        hdlc_addr_cmp #(.W(W)) u_cmp (
            .value  (lo_byte),
            .ref_val(lo_ref[g]),
            .dc_mask(lo_dc[g]),
            .hit    (lo_hit[g])
        );
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign pair_hit[p] = hi_hit[p / NUM_LO] & lo_hit[p % NUM_LO];
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        cr  = 1'b0;
        if (two_byte) begin
            // Descending scan: the lowest matching pair is written last.
            for (int p = NUM_PAIRS - 1; p >= 0; p--) begin
                if (pair_hit[p]) begin
                    hit = 1'b1;
                    idx = IDX_W'(p);
                end
            end
            cr = cr_ignore & hi_byte[CR_BIT];
        end else begin
            hit = |lo_hit;
            idx = lo_hit[0] ? '0 : IDX_W'(1);
            cr  = lo_hit[0];
        end
    end
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
    import hdlc_addr_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_sof,
    input  logic             rx_valid,
    input  logic [W-1:0]     rx_byte,
    input  logic             rx_eof,
    input  logic             cfg_two_byte,
    input  logic             cfg_cr_ignore,
    input  logic [W-1:0]     cfg_hi1,
    input  logic [W-1:0]     cfg_hi2,
    input  logic [W-1:0]     cfg_lo1,
    input  logic [W-1:0]     cfg_lo2,
    input  logic [W-1:0]     cfg_hi_mask,
    input  logic [W-1:0]     cfg_lo_mask,
    output logic             addr_done,
    output logic             addr_accept,
    output logic             addr_auto,
    output logic             addr_cr,
    output logic [IDX_W-1:0] addr_idx,
    output logic             out_valid,
    output logic [W-1:0]     out_byte
);
    filt_state_t      st_d, st_q;
    logic             m_hit;
    logic [IDX_W-1:0] m_idx;
    logic             m_cr;

    hdlc_addr_match #(.W(W)) u_match (
        .two_byte (cfg_two_byte),
        .cr_ignore(cfg_cr_ignore),
        .hi_byte  (st_q.hi_byte),
        .lo_byte  (rx_byte),
        .hi1      (cfg_hi1),
        .hi2      (cfg_hi2),
        .lo1      (cfg_lo1),
        .lo2      (cfg_lo2),
        .hi_mask  (cfg_hi_mask),
        .lo_mask  (cfg_lo_mask),
        .hit      (m_hit),
        .idx      (m_idx),
        .cr       (m_cr)
    );

    always_comb begin
        st_d = st_q;
        if (rx_sof) begin
            st_d          = '0;
            st_d.in_frame = 1'b1;
        end else if (st_q.in_frame) begin
            if (rx_valid && !st_q.done) begin
                if (cfg_two_byte && !st_q.got_hi) begin
                    st_d.got_hi  = 1'b1;
                    st_d.hi_byte = rx_byte;
                end else begin
                    st_d.done   = 1'b1;
                    st_d.accept = m_hit;
                    st_d.auto_f = m_hit && (m_idx == '0);
                    st_d.cr     = m_hit & m_cr;
                    st_d.idx    = m_hit ? m_idx : '0;
                end
            end
            if (rx_eof) begin
                st_d.in_frame = 1'b0;
                if (!st_d.done) begin
                    st_d.done   = 1'b1;
                    st_d.accept = 1'b0;
                    st_d.auto_f = 1'b0;
                    st_d.cr     = 1'b0;
                    st_d.idx    = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_done   = st_q.done;
    assign addr_accept = st_q.accept;
    assign addr_auto   = st_q.auto_f;
    assign addr_cr     = st_q.cr;
    assign addr_idx    = st_q.idx;
    assign out_valid   = rx_valid && !rx_sof && st_q.in_frame && st_q.done && st_q.accept;
    assign out_byte    = rx_byte;
endmodule

// File: rtl/hdlc_addr_filter_chk.sv
module hdlc_addr_filter_chk
    import hdlc_addr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rx_sof,
    input logic             rx_valid,
    input logic             rx_eof,
    input logic             addr_done,
    input logic             addr_accept,
    input logic             addr_auto,
    input logic             addr_cr,
    input logic [IDX_W-1:0] addr_idx,
    input logic             out_valid
);
    assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rx_valid && addr_done && addr_accept));

    assert_auto_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_auto |-> (addr_accept && addr_idx == '0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_done && !rx_sof) |=> $stable({addr_done, addr_accept, addr_auto, addr_cr, addr_idx}));

    assert_sof_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sof |=> !addr_done);

    assert_short_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eof && !addr_done && !rx_valid && !rx_sof) |=> (addr_done && !addr_accept));

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |-> (32'(addr_idx) < NUM_PAIRS));
endmodule

bind hdlc_addr_filter hdlc_addr_filter_chk u_chk (.*);

// File: tb/tb_hdlc_addr_filter.sv
module tb_hdlc_addr_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_sof = 0, rx_valid = 0, rx_eof = 0;
    logic [7:0] rx_byte = '0;
    logic       cfg_two_byte = 1, cfg_cr_ignore = 0;
    logic [7:0] cfg_hi1 = 0, cfg_hi2 = 0, cfg_lo1 = 0, cfg_lo2 = 0;
    logic [7:0] cfg_hi_mask = 0, cfg_lo_mask = 0;
    logic       addr_done, addr_accept, addr_auto, addr_cr, out_valid;
    logic [2:0] addr_idx;
    logic [7:0] out_byte;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 0;

    always #2.5 clk = ~clk;

    hdlc_addr_filter dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Expected decision from the requirements: {accept, auto, cr, idx}
    function automatic logic [5:0] expect_dec(input logic two, input logic [7:0] b0, input logic [7:0] b1);
        logic [7:0] crm, hmask, lo;
        logic       h [3];
        logic       l [2];
        logic       acc, cr;
        logic [2:0] idx;
        crm   = cfg_cr_ignore ? 8'h02 : 8'h00;
        hmask = cfg_hi_mask | crm;
        lo    = two ? b1 : b0;
        h[0]  = ((b0 ^ cfg_hi1) & ~hmask) == 0;
        h[1]  = ((b0 ^ cfg_hi2) & ~hmask) == 0;
        h[2]  = ((b0 ^ 8'hFE) & ~crm) == 0;
        l[0]  = ((lo ^ cfg_lo1) & ~cfg_lo_mask) == 0;
        l[1]  = ((lo ^ cfg_lo2) & ~cfg_lo_mask) == 0;
        acc = 0; idx = 0; cr = 0;
        if (two) begin
            for (int p = 0; p < 6; p++)
                if (!acc && h[p / 2] && l[p % 2]) begin acc = 1; idx = 3'(p); end
            cr = acc & cfg_cr_ignore & b0[1];
        end else begin
            acc = l[0] | l[1];
            idx = l[0] ? 3'd0 : (acc ? 3'd1 : 3'd0);
            cr  = l[0];
        end
        return {acc, acc && idx == 0, cr, idx};
    endfunction

    task automatic run_frame(input logic [7:0] b0, input logic [7:0] b1, input string req);
        logic [5:0] e;
        e = expect_dec(cfg_two_byte, b0, b1);
        @(negedge clk); rx_sof = 1;
        @(negedge clk); rx_sof = 0; rx_valid = 1; rx_byte = b0;
        #1 chk(out_valid == 0, "R9 addr byte gated", out_valid, 0);
        if (cfg_two_byte) begin
            @(negedge clk); rx_byte = b1;
            #1 chk(out_valid == 0, "R9 addr byte gated", out_valid, 0);
        end
        @(negedge clk); rx_valid = 0;
        chk(addr_done && {addr_accept, addr_auto, addr_cr, addr_idx} == e, req,
            {addr_done, addr_accept, addr_auto, addr_cr, addr_idx}, {1'b1, e});
        rx_valid = 1; rx_byte = 8'hA5;
        #1 chk(out_valid == e[5] && out_byte == 8'hA5, "R9 payload gating", out_valid, e[5]);
        @(negedge clk); rx_valid = 0; rx_eof = 1;
        @(negedge clk); rx_eof = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({addr_done, addr_accept, addr_auto, addr_cr, addr_idx, out_valid} == 0, "R10 reset",
            {addr_done, addr_accept, addr_auto, addr_cr, addr_idx, out_valid}, 0);
        rst_n = 1;

        // R1 plain two-byte sweep
        cfg_two_byte = 1; cfg_cr_ignore = 0;
        cfg_hi1 = 8'h20; cfg_hi2 = 8'h44; cfg_lo1 = 8'h11; cfg_lo2 = 8'h7E;
        for (int h = 0; h < 256; h++) begin
            run_frame(8'(h), 8'h11, "R1 R3 R4 sweep lo1");
            run_frame(8'(h), 8'h7E, "R1 R3 sweep lo2");
            run_frame(8'(h), 8'h13, "R1 sweep no lo");
        end

        // R2 command/response bit ignored, overlapping candidates for priority
        cfg_cr_ignore = 1;
        cfg_hi1 = 8'h20; cfg_hi2 = 8'h22; cfg_lo1 = 8'h11; cfg_lo2 = 8'h11;
        for (int h = 0; h < 256; h++) begin
            run_frame(8'(h), 8'h11, "R2 R3 priority sweep");
            run_frame(8'(h), 8'h10, "R2 sweep no lo");
        end
        cfg_hi1 = 8'h00; cfg_hi2 = 8'h01; cfg_lo2 = 8'h33;
        run_frame(8'hFC, 8'h33, "R2 group with cr bit clear");
        run_frame(8'hFE, 8'h11, "R2 group with cr bit set");

        // R6 masks (group value unmasked)
        cfg_cr_ignore = 0;
        cfg_hi1 = 8'h30; cfg_hi2 = 8'h81; cfg_lo1 = 8'h05; cfg_lo2 = 8'h50;
        cfg_hi_mask = 8'h0F; cfg_lo_mask = 8'hF0;
        for (int h = 0; h < 256; h++) begin
            run_frame(8'(h), 8'hA5, "R6 masked sweep");
            run_frame(8'(h), 8'h5A, "R6 masked sweep b");
        end
        cfg_hi1 = 8'h00; cfg_hi2 = 8'h00;
        run_frame(8'hF0, 8'h05, "R6 group ignores hi mask");

        // R5 one-byte mode sweeps
        cfg_two_byte = 0; cfg_hi_mask = 0; cfg_lo_mask = 0;
        cfg_hi1 = 8'h03; cfg_hi2 = 8'h01; cfg_lo1 = 8'h03; cfg_lo2 = 8'h01;
        for (int b = 0; b < 256; b++) run_frame(8'(b), 8'h00, "R5 one-byte sweep");
        cfg_lo_mask = 8'h80; cfg_lo2 = 8'h83; cfg_hi1 = 8'h77; cfg_hi2 = 8'h77;
        for (int b = 0; b < 256; b++) run_frame(8'(b), 8'h00, "R5 R4 one-byte masked sweep");

        // R8 short frames
        cfg_two_byte = 1; cfg_lo_mask = 0; cfg_hi1 = 8'h20; cfg_lo1 = 8'h11;
        @(negedge clk); rx_sof = 1;
        @(negedge clk); rx_sof = 0; rx_valid = 1; rx_byte = 8'h20;
        @(negedge clk); rx_valid = 0; rx_eof = 1;
        @(negedge clk); rx_eof = 0;
        chk(addr_done && !addr_accept, "R8 one addr byte then end", {addr_done, addr_accept}, 2'b10);
        @(negedge clk); rx_sof = 1;
        @(negedge clk); rx_sof = 0;
        chk(!addr_done, "R7 start clears decision", addr_done, 0);
        rx_eof = 1;
        @(negedge clk); rx_eof = 0;
        chk(addr_done && !addr_accept, "R8 empty frame", {addr_done, addr_accept}, 2'b10);

        // R7 hold across config change, R9 stray byte outside frame
        run_frame(8'h20, 8'h11, "R4 auto pair");
        cfg_hi1 = 8'h55; cfg_two_byte = 0;
        @(negedge clk); @(negedge clk);
        chk(addr_done && addr_accept && addr_auto && addr_idx == 0, "R7 decision held",
            {addr_done, addr_accept, addr_auto, addr_idx}, 6'b111000);
        rx_valid = 1; rx_byte = 8'h5A;
        #1 chk(out_valid == 0, "R9 byte outside frame", out_valid, 0);
        @(negedge clk); rx_valid = 0;

        finish_run();
    end
endmodule